// File: doc/BRIEF.md
# Saturating Signed Adder/Subtractor with Condition Flags

This block adds or subtracts two signed two's-complement operands and delivers the result together with zero, sign, carry and overflow flags. When the signed result does not fit, the output is clamped to the nearest representable extreme. A sticky saturation flag records that a clamp has happened at some point. It stays set until an external clear input drops it. For subtraction, the first operand is taken from the second operand.

Operations enter through a valid/ready handshake and leave through a one-entry registered output stage with its own valid/ready pair. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. While `res_valid` is high and `res_ready` is low, the result and all four per-operation flags hold, and no new operation is accepted. The flags are registered state: they keep the values of the last accepted operation until the next one is accepted. The sticky flag and its clear input are plain status and control pins.

The operand width is the parameter `W`, which defaults to 32.

Top module: `sat_addsub`

## Requirements
- R1: `op_sub`=0 selects `op_b + op_a` and `op_sub`=1 selects `op_b - op_a`. When no overflow occurs, `res_data` equals the wrapped W-bit result.
- R2: For addition, `flag_cy` is the unsigned carry out of bit W-1. For subtraction, `flag_cy` is 1 exactly when `op_b < op_a` as unsigned values.
- R3: For addition, `flag_ov` is 1 when `op_a` and `op_b` have the same sign bit and the wrapped result has the other sign bit.
- R4: For subtraction, `flag_ov` is 1 when the sign bits of `op_a` and `op_b` differ and the sign bit of the wrapped result differs from the sign bit of `op_b`.
- R5: On overflow, `res_data` clamps depending on the sign bit of the wrapped result. If that bit is 1, the output is the largest positive value (0x7FFFFFFF at W=32). If that bit is 0, the output is the most negative value (0x80000000 at W=32).
- R6: `flag_z` is 1 exactly when the wrapped, unclamped result is zero. For example, 0x80000000 + 0x80000000 gives `flag_z`=1 with `res_data`=0x80000000.
- R7: `flag_s` equals bit W-1 of the delivered (possibly clamped) `res_data`.
- R8: `flag_sat` becomes 1 on any accepted operation that overflows. Accepted operations never clear it.
- R9: `sat_clr`=1 clears `flag_sat` on the next edge. If an overflowing operation is accepted on that same edge, `flag_sat` ends at 1.
- R10: `in_ready` equals `!res_valid || res_ready`. While stalled, `res_data`, `res_valid` and the four per-operation flags hold, and an offered operation is not consumed.
- R11: After reset, `res_valid` is 0, all five flags are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted this cycle |
| op_sub | input | 1 | 0 = add, 1 = subtract (`op_b - op_a`) |
| op_a | input | W | First operand (subtrahend when subtracting) |
| op_b | input | W | Second operand (minuend when subtracting) |
| res_valid | output | 1 | Output stage holds a result |
| res_ready | input | 1 | Consumer takes the result this cycle |
| res_data | output | W | Saturated result |
| flag_z | output | 1 | Wrapped result was zero |
| flag_s | output | 1 | Sign of the delivered result |
| flag_cy | output | 1 | Carry (add) or borrow (subtract) |
| flag_ov | output | 1 | Signed overflow of the last operation |
| flag_sat | output | 1 | Sticky saturation flag |
| sat_clr | input | 1 | Clears the sticky saturation flag |

## Verification
A 6-bit instance is swept over every operand pair, in both add and subtract modes. This sweep separates a correct borrow from an inverted carry, and it separates the two overflow rules, because each mode meets every sign combination. Wrapped results equal to zero under overflow (the most-negative value plus itself) show that the zero flag comes from the unclamped sum while the sign flag follows the clamped value. Directed patterns then cover three cases: a clear pulse with no operation, a clear that coincides with an overflow, and an operation offered while the output is held, which must not be consumed.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef struct packed {
    logic z;
    logic s;
    logic cy;
    logic ov;
  } ccode_t;
endpackage

// File: rtl/sat_wrap_add.sv
// Shared adder: one carry chain serves both modes by inverting op_a.
module sat_wrap_add #(
  parameter int W = 32
) (
  input  logic         sub,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] wrapped,
  output logic         carry,
  output logic         ovf
);
  localparam int MSB = W - 1;

  logic [W-1:0] a_eff;
  logic [W:0]   sum;

  always_comb begin
    a_eff   = sub ? ~a : a;
    sum     = {1'b0, b} + {1'b0, a_eff} + {{W{1'b0}}, sub};
    wrapped = sum[W-1:0];
    // subtraction: no carry out of b + ~a + 1 means b < a unsigned
    carry   = sub ? ~sum[W] : sum[W];
    // same sign on adder inputs, different sign on output
    ovf     = (a_eff[MSB] == b[MSB]) && (wrapped[MSB] != b[MSB]);
  end
endmodule

// File: rtl/sat_clamp.sv
// Clamp to the signed extremes and form Z/S.
module sat_clamp #(
  parameter int W = 32
) (
  input  logic [W-1:0]    wrapped,
  input  logic            carry,
  input  logic            ovf,
  output logic [W-1:0]    result,
  output sat_pkg::ccode_t cc
);
  localparam int MSB = W - 1;
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

  always_comb begin
    if (ovf) result = wrapped[MSB] ? POS_MAX : NEG_MIN;
    else     result = wrapped;
    cc.z  = (wrapped == '0);
    cc.s  = result[MSB];
    cc.cy = carry;
    cc.ov = ovf;
  end
endmodule

// File: rtl/sat_out_stage.sv
// One-entry output register plus flag state and the sticky bit.
module sat_out_stage #(
  parameter int W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [W-1:0]    result,
  input  sat_pkg::ccode_t cc,
  input  logic            res_ready,
  input  logic            sat_clr,
  output logic            full,
  output logic [W-1:0]    data_q,
  output sat_pkg::ccode_t cc_q,
  output logic            sat_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full   <= 1'b0;
      data_q <= '0;
      cc_q   <= '0;
      sat_q  <= 1'b0;
    end else begin
      if (take) begin
        full   <= 1'b1;
        data_q <= result;
        cc_q   <= cc;
      end else if (res_ready) begin
        full   <= 1'b0;
      end
      // a new saturation outranks a clear on the same edge
      sat_q <= (sat_q && !sat_clr) || (take && cc.ov);
    end
  end
endmodule

// File: rtl/sat_addsub.sv
module sat_addsub #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         op_sub,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         res_valid,
  input  logic         res_ready,
  output logic [W-1:0] res_data,
  output logic         flag_z,
  output logic         flag_s,
  output logic         flag_cy,
  output logic         flag_ov,
  output logic         flag_sat,
  input  logic         sat_clr
);
  logic [W-1:0]    wrapped;
  logic            carry;
  logic            ovf;
  logic [W-1:0]    clamped;
  sat_pkg::ccode_t cc_d;
  sat_pkg::ccode_t cc_q;
  logic            full;
  logic            take;

  assign in_ready = !full || res_ready;
  assign take     = in_valid && in_ready;

  sat_wrap_add #(.W(W)) u_add (
    .sub(op_sub), .a(op_a), .b(op_b),
    .wrapped(wrapped), .carry(carry), .ovf(ovf)
  );

  sat_clamp #(.W(W)) u_clamp (
    .wrapped(wrapped), .carry(carry), .ovf(ovf),
    .result(clamped), .cc(cc_d)
  );

  sat_out_stage #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .take(take), .result(clamped), .cc(cc_d),
    .res_ready(res_ready), .sat_clr(sat_clr),
    .full(full), .data_q(res_data), .cc_q(cc_q), .sat_q(flag_sat)
  );

  assign res_valid = full;
  assign flag_z    = cc_q.z;
  assign flag_s    = cc_q.s;
  assign flag_cy   = cc_q.cy;
  assign flag_ov   = cc_q.ov;
endmodule

// File: rtl/sat_addsub_chk.sv
module sat_addsub_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         res_valid,
  input logic         res_ready,
  input logic [W-1:0] res_data,
  input logic         flag_z,
  input logic         flag_s,
  input logic         flag_cy,
  input logic         flag_ov,
  input logic         flag_sat,
  input logic         sat_clr
);
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

  AST_CLAMP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && flag_ov |-> (res_data == POS_MAX || res_data == NEG_MIN)); // R5

  AST_CLAMP_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && flag_ov |-> (flag_s == (res_data == NEG_MIN))); // R7

  AST_ZERO_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !flag_ov |-> (flag_z == (res_data == '0))); // R6

  AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_sat && !sat_clr |=> flag_sat); // R8

  AST_OVF_SETS_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> (!flag_ov || flag_sat)); // R9

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(flag_ov)
      && $stable(flag_cy) && $stable(flag_z) && $stable(flag_s)); // R10

  AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !in_ready); // R10
endmodule

bind sat_addsub sat_addsub_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
  .flag_z(flag_z), .flag_s(flag_s), .flag_cy(flag_cy), .flag_ov(flag_ov),
  .flag_sat(flag_sat), .sat_clr(sat_clr)
);

// File: tb/sat_addsub_tb.sv
module sat_addsub_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BW    = 6;
  localparam int N     = 1 << BW;
  localparam int MASK  = N - 1;
  localparam int PMAX  = (1 << (BW - 1)) - 1;
  localparam int NMIN  = 1 << (BW - 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic          op_sub = 1'b0;
  logic [BW-1:0] op_a = '0;
  logic [BW-1:0] op_b = '0;
  logic          res_valid;
  logic          res_ready = 1'b1;
  logic [BW-1:0] res_data;
  logic          flag_z, flag_s, flag_cy, flag_ov, flag_sat;
  logic          sat_clr = 1'b0;

  int  n_run = 0;
  int  n_fail = 0;
  int  exp_sat = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sat_addsub #(.W(BW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_sub(op_sub), .op_a(op_a), .op_b(op_b), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .flag_z(flag_z),
    .flag_s(flag_s), .flag_cy(flag_cy), .flag_ov(flag_ov),
    .flag_sat(flag_sat), .sat_clr(sat_clr)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (a=%0d b=%0d sub=%0d)",
               tag, act, exp, op_a, op_b, op_sub);
    end
  endtask

  function automatic int msb(input int x);
    return (x >> (BW - 1)) & 1;
  endfunction

  // drives one operation at a negedge, checks one cycle later
  task automatic run_op(input int sub, input int a, input int b);
    int r, cy, ov, res;
    op_sub = sub[0];
    op_a = BW'(a);
    op_b = BW'(b);
    in_valid = 1'b1;
    if (sub == 0) begin
      r  = (a + b) & MASK;
      cy = ((a + b) >> BW) & 1;
      ov = (msb(a) == msb(b) && msb(r) != msb(a)) ? 1 : 0;
    end else begin
      r  = (b - a) & MASK;
      cy = (b < a) ? 1 : 0;
      ov = (msb(a) != msb(b) && msb(r) != msb(b)) ? 1 : 0;
    end
    res = ov ? (msb(r) ? PMAX : NMIN) : r;
    if (sat_clr) exp_sat = 0;
    if (ov) exp_sat = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(ov ? "R5" : "R1", int'(res_data), res);
    check("R2", int'(flag_cy), cy);
    check(sub ? "R4" : "R3", int'(flag_ov), ov);
    check("R6", int'(flag_z), (r == 0) ? 1 : 0);
    check("R7", int'(flag_s), msb(res));
    check("R8", int'(flag_sat), exp_sat);
    check("R10", int'(res_valid), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", int'(res_valid), 0);
    check("R11", int'({flag_z, flag_s, flag_cy, flag_ov, flag_sat}), 0);
    check("R11", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // exhaustive sweep, both modes
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < N; a++)
        for (int b = 0; b < N; b++)
          run_op(s, a, b);

    // R6 example: most-negative plus itself
    run_op(0, NMIN, NMIN);
    check("R6", int'(flag_z), 1);
    check("R5", int'(res_data), NMIN);

    // R9: clear alone
    sat_clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sat_clr = 1'b0;
    exp_sat = 0;
    check("R9", int'(flag_sat), 0);
    check("R10", int'(res_valid), 0);
    // R9: clear coincides with overflow, set wins
    sat_clr = 1'b1;
    run_op(0, PMAX, 1);
    sat_clr = 1'b0;
    check("R9", int'(flag_sat), 1);
    // R9: clear with non-overflowing op
    sat_clr = 1'b1;
    run_op(0, 1, 2);
    sat_clr = 1'b0;
    check("R9", int'(flag_sat), 0);

    // R10: stall holds result and does not consume the offer
    run_op(1, 5, 3);
    res_ready = 1'b0;
    op_sub = 1'b0;
    op_a = BW'(1);
    op_b = BW'(2);
    in_valid = 1'b1;
    #1;
    check("R10", int'(in_ready), 0);
    @(posedge clk);
    @(negedge clk);
    check("R10", int'(res_data), (3 - 5) & MASK);
    check("R10", int'(flag_cy), 1);
    check("R10", int'(res_valid), 1);
    res_ready = 1'b1;
    #1;
    check("R10", int'(in_ready), 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10", int'(res_data), 3);
    check("R10", int'(flag_cy), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule